// File: doc/BRIEF.md
# Home-Node Coherence Directory with Presence Vectors

This block sits at the home node of a small shared-memory multiprocessor and keeps the coherence state for every memory line that the node owns. Each line has a directory entry holding one presence bit per node and a dirty flag, and the line data is held in a small synchronous memory inside the block. Caches send it three kinds of message on a valid/ready request port: a read miss, a write miss, and an owner writeback. The block answers on a reply port, one cycle after it accepts a request.

A read miss to a clean line is answered with the line data, and the requester becomes a sharer. A read miss to a dirty line is answered with the identity of the owning node and no data. The requester then fetches the line from that owner, and the owner's writeback later makes the entry clean again. A write miss is answered with the data and the mask of the other nodes that hold copies. The requester invalidates those nodes and collects their acknowledgements itself. It may not complete the write until every sharer named in the mask has acknowledged. While an owner transfer is pending on a line, new read and write misses to that line are held off by dropping ready.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset, req_ready is high, rsp_valid is low, and every entry is clean with no presence bits. A first write miss to a line therefore returns an empty sharer mask.
- R2: A read miss to a clean line produces a reply with rsp_kind 0 (data) carrying the line's memory contents, and it adds the requester to the presence set.
- R3: A read miss to a dirty line produces a reply with rsp_kind 1 (owner) whose rsp_owner is the dirty line's single present node. It marks the line as waiting for that owner's transfer, and presence and dirty are left unchanged.
- R4: While a line waits for an owner transfer, req_ready is low for read misses (req_kind 0) and write misses (req_kind 1) to that line. Requests to other lines and writebacks (req_kind 2) are still accepted.
- R5: A writeback to a waiting line writes req_data to memory, clears dirty and ends the wait. The presence set becomes the previous owner plus the waiting requester. No reply is produced.
- R6: A write miss produces a reply with rsp_kind 2 (grant) carrying the line's memory contents and the mask of the nodes present before the request.
- R7: The sharer mask in a grant never includes the requester's own bit, even if that node was present.
- R8: After a write miss, the line is dirty and only the writer's presence bit is set.
- R9: A writeback to a line that is not waiting writes req_data to memory, clears dirty and removes the writing node from the presence set. No reply is produced.
- R10: A reply appears exactly one cycle after a read or write miss is accepted, and at no other time. Its rsp_node and rsp_line echo the request's node and line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 owner writeback |
| req_node | input | 3 | Sending node id |
| req_line | input | 4 | Line index |
| req_data | input | 32 | Line data for a writeback |
| rsp_valid | output | 1 | Reply present (single cycle) |
| rsp_kind | output | 2 | 0 data, 1 owner id, 2 grant with sharers |
| rsp_node | output | 3 | Destination node (the requester) |
| rsp_line | output | 4 | Line index of the reply |
| rsp_owner | output | 3 | Owning node for an owner reply |
| rsp_sharers | output | 8 | Nodes to invalidate for a grant |
| rsp_data | output | 32 | Line data for data and grant replies |

## Verification
The bench builds the block with its defaults: 8 nodes, 16 lines and 32-bit data. With 8 nodes, a single line can collect several sharers, and a grant mask can be checked with the requester both inside and outside the presence set. With 16 lines, one line can wait on an owner transfer while a neighbouring line is still serviced. This exercises both sides of the stall rule. A behavioural model holds the presence sets, dirty flags, waiting requesters and memory contents. Every reply field is compared with this model on each clock.

// File: rtl/dir_pkg.sv
package dir_pkg;
    localparam int unsigned DIR_NODES  = 8;
    localparam int unsigned DIR_LINES  = 16;
    localparam int unsigned DIR_DATA_W = 32;
    localparam int unsigned NODE_W     = $clog2(DIR_NODES);
    localparam int unsigned LINE_W     = $clog2(DIR_LINES);

    typedef logic [DIR_NODES-1:0]  node_mask_t;
    typedef logic [NODE_W-1:0]     node_id_t;
    typedef logic [LINE_W-1:0]     line_idx_t;
    typedef logic [DIR_DATA_W-1:0] line_data_t;

    typedef enum logic [1:0] {
        REQ_READ  = 2'd0,
        REQ_WRITE = 2'd1,
        REQ_WBACK = 2'd2
    } req_kind_e;

    typedef enum logic [1:0] {
        RSP_DATA  = 2'd0,
        RSP_OWNER = 2'd1,
        RSP_GRANT = 2'd2
    } rsp_kind_e;

    typedef struct packed {
        node_mask_t present;
        logic       dirty;
        logic       waiting;
        node_id_t   waiter;
    } dir_entry_t;

    function automatic node_mask_t id_to_mask(node_id_t id);
        return node_mask_t'(1) << id;
    endfunction

    function automatic node_id_t mask_to_id(node_mask_t m);
        node_id_t id;
        id = '0;
        for (int i = DIR_NODES - 1; i >= 0; i--) begin
            if (m[i]) id = node_id_t'(i);
        end
        return id;
    endfunction
endpackage

// File: rtl/dir_entry_store.sv
module dir_entry_store
    import dir_pkg::*;
#(
    parameter int unsigned LINES = DIR_LINES,
    parameter int unsigned NODES = DIR_NODES
) (
    input  logic                        clk,
    input  logic                        rst,
    input  line_idx_t                   rd_line,
    output dir_entry_t                  rd_entry,
    input  logic                        wr_en,
    input  line_idx_t                   wr_line,
    input  dir_entry_t                  wr_entry,
    output logic [LINES-1:0][NODES-1:0] all_present,
    output logic [LINES-1:0]            all_dirty,
    output logic [LINES-1:0]            all_waiting
);
    dir_entry_t entry_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                entry_q[g] <= '0;
            end else if (wr_en && wr_line == line_idx_t'(g)) begin
                entry_q[g] <= wr_entry;
            end
        end
        assign all_present[g] = entry_q[g].present;
        assign all_dirty[g]   = entry_q[g].dirty;
        assign all_waiting[g] = entry_q[g].waiting;
    end

    assign rd_entry = entry_q[rd_line];
endmodule

// File: rtl/dir_line_mem.sv
module dir_line_mem
    import dir_pkg::*;
#(
    parameter int unsigned LINES = DIR_LINES
) (
    input  logic       clk,
    input  logic       we,
    input  line_idx_t  waddr,
    input  line_data_t wdata,
    input  logic       re,
    input  line_idx_t  raddr,
    output line_data_t rdata
);
    line_data_t store_q [LINES];

    always_ff @(posedge clk) begin
        if (we) store_q[waddr] <= wdata;
        if (re) rdata <= store_q[raddr];
    end
endmodule

// File: rtl/dir_decide.sv
module dir_decide
    import dir_pkg::*;
(
    input  req_kind_e  kind,
    input  node_id_t   node,
    input  dir_entry_t cur,
    output logic       ready,
    output dir_entry_t nxt,
    output logic       mem_we,
    output logic       rsp_fire,
    output rsp_kind_e  rsp_kind,
    output node_id_t   rsp_owner,
    output node_mask_t rsp_sharers
);
    node_mask_t self_bit;
    assign self_bit = id_to_mask(node);

    always_comb begin
        nxt         = cur;
        mem_we      = 1'b0;
        rsp_fire    = 1'b0;
        rsp_kind    = RSP_DATA;
        rsp_owner   = '0;
        rsp_sharers = '0;
        ready       = !(cur.waiting && kind != REQ_WBACK);
        case (kind)
            REQ_READ: begin
                rsp_fire = 1'b1;
                if (cur.dirty) begin
                    rsp_kind    = RSP_OWNER;
                    rsp_owner   = mask_to_id(cur.present);
                    nxt.waiting = 1'b1;
                    nxt.waiter  = node;
                end else begin
                    nxt.present = cur.present | self_bit;
                end
            end
            REQ_WRITE: begin
                rsp_fire    = 1'b1;
                rsp_kind    = RSP_GRANT;
                rsp_sharers = cur.present & ~self_bit;
                nxt.present = self_bit;
                nxt.dirty   = 1'b1;
            end
            REQ_WBACK: begin
                mem_we    = 1'b1;
                nxt.dirty = 1'b0;
                if (cur.waiting) begin
                    nxt.present = cur.present | id_to_mask(cur.waiter);
                    nxt.waiting = 1'b0;
                end else begin
                    nxt.present = cur.present & ~self_bit;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
    import dir_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [1:0]  req_kind,
    input  logic [2:0]  req_node,
    input  logic [3:0]  req_line,
    input  logic [31:0] req_data,
    output logic        rsp_valid,
    output logic [1:0]  rsp_kind,
    output logic [2:0]  rsp_node,
    output logic [3:0]  rsp_line,
    output logic [2:0]  rsp_owner,
    output logic [7:0]  rsp_sharers,
    output logic [31:0] rsp_data
);
    dir_entry_t cur_entry, nxt_entry;
    logic       accept, mem_we, fire;
    rsp_kind_e  d_kind;
    node_id_t   d_owner;
    node_mask_t d_sharers;
    logic [DIR_LINES-1:0][DIR_NODES-1:0] dir_present;
    logic [DIR_LINES-1:0]                dir_dirty;
    logic [DIR_LINES-1:0]                dir_waiting;

    dir_entry_store #(.LINES(DIR_LINES), .NODES(DIR_NODES)) u_store (
        .clk(clk), .rst(rst),
        .rd_line(line_idx_t'(req_line)), .rd_entry(cur_entry),
        .wr_en(accept), .wr_line(line_idx_t'(req_line)), .wr_entry(nxt_entry),
        .all_present(dir_present), .all_dirty(dir_dirty), .all_waiting(dir_waiting)
    );

    dir_decide u_decide (
        .kind(req_kind_e'(req_kind)), .node(node_id_t'(req_node)), .cur(cur_entry),
        .ready(req_ready), .nxt(nxt_entry), .mem_we(mem_we), .rsp_fire(fire),
        .rsp_kind(d_kind), .rsp_owner(d_owner), .rsp_sharers(d_sharers)
    );

    assign accept = req_valid && req_ready;

    dir_line_mem #(.LINES(DIR_LINES)) u_mem (
        .clk(clk),
        .we(accept && mem_we), .waddr(line_idx_t'(req_line)), .wdata(line_data_t'(req_data)),
        .re(accept && fire), .raddr(line_idx_t'(req_line)), .rdata(rsp_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid   <= 1'b0;
            rsp_kind    <= '0;
            rsp_node    <= '0;
            rsp_line    <= '0;
            rsp_owner   <= '0;
            rsp_sharers <= '0;
        end else begin
            rsp_valid <= accept && fire;
            if (accept && fire) begin
                rsp_kind    <= d_kind;
                rsp_node    <= req_node;
                rsp_line    <= req_line;
                rsp_owner   <= d_owner;
                rsp_sharers <= d_sharers;
            end
        end
    end
endmodule

// File: rtl/dir_home_sva.sv
module dir_home_sva #(
    parameter int unsigned LINES = 16,
    parameter int unsigned NODES = 8
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        req_valid,
    input logic                        req_ready,
    input logic [1:0]                  req_kind,
    input logic [3:0]                  req_line,
    input logic                        rsp_valid,
    input logic [1:0]                  rsp_kind,
    input logic [2:0]                  rsp_node,
    input logic [3:0]                  rsp_line,
    input logic [7:0]                  rsp_sharers,
    input logic [LINES-1:0][NODES-1:0] all_present,
    input logic [LINES-1:0]            all_dirty,
    input logic [LINES-1:0]            all_waiting
);
    logic miss_acc;
    assign miss_acc = req_valid && req_ready && (req_kind == 2'd0 || req_kind == 2'd1);

    p_reply_follows_r10: assert property (@(posedge clk) disable iff (rst)
        miss_acc |=> rsp_valid);
    p_no_stray_reply_r10: assert property (@(posedge clk) disable iff (rst)
        !miss_acc |=> !rsp_valid);
    p_stall_waiting_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && all_waiting[req_line] && req_kind != 2'd2) |-> !req_ready);
    p_owner_sets_wait_r3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_kind == 2'd1) |-> all_waiting[rsp_line]);
    p_mask_excludes_self_r7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_kind == 2'd2) |-> !rsp_sharers[rsp_node]);
    p_grant_sole_owner_r8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_kind == 2'd2) |->
            (all_dirty[rsp_line] && all_present[rsp_line] == (NODES'(1) << rsp_node)));
    p_dirty_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        all_dirty[req_line] |-> $onehot(all_present[req_line]));
endmodule

bind dir_home_ctrl dir_home_sva #(.LINES(dir_pkg::DIR_LINES), .NODES(dir_pkg::DIR_NODES)) u_sva (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_line(req_line), .rsp_valid(rsp_valid),
    .rsp_kind(rsp_kind), .rsp_node(rsp_node), .rsp_line(rsp_line),
    .rsp_sharers(rsp_sharers), .all_present(dir_present),
    .all_dirty(dir_dirty), .all_waiting(dir_waiting)
);

// File: tb/dir_home_ctrl_tb.sv
module dir_home_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = '0;
    logic [2:0]  req_node = '0;
    logic [3:0]  req_line = '0;
    logic [31:0] req_data = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_kind;
    logic [2:0]  rsp_node;
    logic [3:0]  rsp_line;
    logic [2:0]  rsp_owner;
    logic [7:0]  rsp_sharers;
    logic [31:0] rsp_data;

    int checks = 0;
    int errors = 0;

    // behavioural model state
    logic [7:0]  m_pres [16];
    logic        m_dirty [16];
    logic        m_wait [16];
    int          m_waiter [16];
    logic [31:0] m_mem [16];

    // expected reply for the next clock
    logic        e_valid = 1'b0;
    logic [1:0]  e_kind;
    logic [2:0]  e_node, e_owner;
    logic [3:0]  e_line;
    logic [7:0]  e_shr;
    logic [31:0] e_data;
    string       e_tag;

    always #4 clk = ~clk;

    dir_home_ctrl u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_node(req_node), .req_line(req_line), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_node(rsp_node), .rsp_line(rsp_line),
        .rsp_owner(rsp_owner), .rsp_sharers(rsp_sharers), .rsp_data(rsp_data)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(posedge clk) begin
        #2;
        if (!rst) begin
            check(rsp_valid == e_valid, {e_tag, " R10 reply timing"}, 64'(rsp_valid), 64'(e_valid));
            if (e_valid && rsp_valid) begin
                check(rsp_kind == e_kind, {e_tag, " kind"}, 64'(rsp_kind), 64'(e_kind));
                check(rsp_node == e_node && rsp_line == e_line, {e_tag, " R10 node/line echo"},
                      64'({rsp_node, rsp_line}), 64'({e_node, e_line}));
                if (e_kind == 2'd1)
                    check(rsp_owner == e_owner, {e_tag, " owner id"}, 64'(rsp_owner), 64'(e_owner));
                else
                    check(rsp_data == e_data, {e_tag, " data"}, 64'(rsp_data), 64'(e_data));
                if (e_kind == 2'd2)
                    check(rsp_sharers == e_shr, {e_tag, " sharer mask"}, 64'(rsp_sharers), 64'(e_shr));
            end
            e_valid = 1'b0;
        end
    end

    task automatic send(input int kind, input int node, input int line, input logic [31:0] data, input string tag);
        logic [7:0] bitn;
        @(negedge clk);
        req_valid = 1'b1;
        req_kind = 2'(kind); req_node = 3'(node); req_line = 4'(line); req_data = data;
        #1;
        check(req_ready == 1'b1, {tag, " R4 ready for accepted request"}, 64'(req_ready), 64'd1);
        bitn = 8'(1) << node;
        e_tag = tag;
        e_node = 3'(node); e_line = 4'(line); e_data = m_mem[line];
        e_shr = '0; e_owner = '0; e_kind = '0;
        case (kind)
            0: begin
                e_valid = 1'b1;
                if (m_dirty[line]) begin
                    e_kind = 2'd1;
                    for (int i = 7; i >= 0; i--) if (m_pres[line][i]) e_owner = 3'(i);
                    m_wait[line] = 1'b1;
                    m_waiter[line] = node;
                end else begin
                    e_kind = 2'd0;
                    m_pres[line] = m_pres[line] | bitn;
                end
            end
            1: begin
                e_valid = 1'b1;
                e_kind = 2'd2;
                e_shr = m_pres[line] & ~bitn;
                m_pres[line] = bitn;
                m_dirty[line] = 1'b1;
            end
            default: begin
                m_mem[line] = data;
                m_dirty[line] = 1'b0;
                if (m_wait[line]) begin
                    m_pres[line] = m_pres[line] | (8'(1) << m_waiter[line]);
                    m_wait[line] = 1'b0;
                end else begin
                    m_pres[line] = m_pres[line] & ~bitn;
                end
            end
        endcase
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic probe_stall(input int kind, input int node, input int line, input string tag);
        @(negedge clk);
        req_valid = 1'b1;
        req_kind = 2'(kind); req_node = 3'(node); req_line = 4'(line);
        #1;
        check(req_ready == 1'b0, {tag, " R4 stalled on waiting line"}, 64'(req_ready), 64'd0);
        #1;
        req_valid = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_pres[i] = '0; m_dirty[i] = 1'b0; m_wait[i] = 1'b0; m_waiter[i] = 0; m_mem[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);
        check(rsp_valid == 1'b0, "R1 no reply after reset", 64'(rsp_valid), 64'd0);

        // R1: a fresh line is clean and empty
        send(2, 0, 9, 32'h0909_0909, "R9 preload line 9");
        send(1, 2, 9, 0, "R1 first write sees no sharers");

        // R2/R6/R7: sharers gather, then write
        send(2, 0, 3, 32'hA5A5_0003, "R9 preload line 3");
        send(0, 1, 3, 0, "R2 clean read n1");
        send(0, 2, 3, 0, "R2 clean read n2");
        send(0, 4, 3, 0, "R2 clean read n4");
        send(1, 4, 3, 0, "R7 write by present node");
        send(1, 1, 3, 0, "R8 write on dirty line names sole owner");

        // R3/R4/R5: owner transfer
        send(0, 5, 3, 0, "R3 read of dirty line");
        probe_stall(0, 6, 3, "R4 read");
        probe_stall(1, 7, 3, "R4 write");
        send(2, 0, 7, 32'h7777_0007, "R4 other line accepted");
        send(0, 6, 7, 0, "R4 other line read");
        send(2, 1, 3, 32'hBEEF_0003, "R5 owner writeback");
        send(0, 6, 3, 0, "R5 read after transfer");
        send(1, 5, 3, 0, "R5 R7 sharers after transfer");

        // R9: writeback without waiter drops presence
        send(2, 5, 3, 32'hC0DE_0003, "R9 eviction writeback");
        send(0, 7, 3, 0, "R9 read after eviction");
        send(1, 7, 3, 0, "R9 R7 sharers after eviction");
        send(1, 0, 7, 0, "R6 grant on line 7");

        repeat (3) @(posedge clk);
        #3;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule